// File: doc/BRIEF.md
# Signed-Count Shift and Rotate Unit

This block is a purely combinational shifter for a vector of parameterized width. An operation select picks logical, arithmetic or rotating movement to the left or to the right. A two's-complement count sets the distance. The result appears on the output in the same cycle as the inputs, so the block fits inside any datapath stage.

A count is read as a number of single-bit steps applied one after another. A negative count performs the opposite-direction partner of the selected operation, using the magnitude as the distance. Distances at or beyond the vector width give the value that repeated single steps would reach. A shift therefore saturates to its fill pattern, while a rotate wraps around modulo the width.

Arithmetic movement to the left copies the least significant bit into the vacated low positions. Arithmetic movement to the right copies the most significant bit into the vacated high positions.

Top module: `shr_unit`

## Requirements
- R1: The operation select codes are 000 logical left, 001 logical right, 010 arithmetic left, 011 arithmetic right, 100 rotate left and 101 rotate right. The output follows the inputs with no clock.
- R2: For every operation code, a count of zero returns the input vector unchanged.
- R3: Each logical left step discards bit W-1 and inserts 0 at bit 0. Each logical right step discards bit 0 and inserts 0 at bit W-1. A count magnitude of W or more yields all zeros; for example, 1011 left by 3 gives 1000 and right by 3 gives 0001.
- R4: Each arithmetic left step discards bit W-1 and inserts a copy of bit 0 at bit 0. For 1011, a count of 1 gives 0111 and a count of 3 gives 1111.
- R5: Each arithmetic right step discards bit 0 and inserts a copy of bit W-1 at bit W-1. For 1011, a count of 1 gives 1101 and a count of 3 gives 1111. A magnitude of W or more on either arithmetic shift fills every bit with the fill bit.
- R6: A rotate left step moves bit W-1 to bit 0, and a rotate right step moves bit 0 to bit W-1. The distance is taken modulo W. For 1011, rotate left by 3 gives 1101 and rotate right by 1 gives 1101.
- R7: A negative count -R gives the partner operation with distance R. The pairs are logical left with logical right, arithmetic left with arithmetic right, and rotate left with rotate right.
- R8: The most negative count value is treated as its true magnitude, with no overflow on negation.
- R9: The reserved codes 110 and 111 pass the input through unchanged.
- R10: Widths from 1 upward are supported. The count port is $clog2(2W+1)+1 bits wide, which covers counts from -2W to +2W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Vector to be shifted or rotated |
| op_i | input | 3 | Operation select |
| count_i | input | CNT_W | Signed step count, two's complement |
| data_o | output | DATA_W | Result vector |

## Verification
The assertions are checked on every evaluation and cover the properties that hold whatever the exact bit pattern is. These are identity for a zero count and for the reserved codes, an all-zero result for saturated logical shifts, a uniform result for saturated arithmetic shifts, and an unchanged population count under rotation. The exact bit placement of each operation at every distance, the pairing of each operation with its partner under negative counts, and the most negative count can only be shown by the bench's scenarios. These scenarios compare each case against a step-by-step reference at widths 1, 4 and 8.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_LSL = 3'b000,
    OP_LSR = 3'b001,
    OP_ASL = 3'b010,
    OP_ASR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101,
    OP_RS6 = 3'b110,
    OP_RS7 = 3'b111
  } shr_op_e;

  typedef enum logic [1:0] {
    K_LOG = 2'd0,
    K_ARI = 2'd1,
    K_ROT = 2'd2
  } shr_kind_e;

endpackage

// File: rtl/shr_count_norm.sv
// Turns (operation, signed count) into direction, kind, bounded amount and
// a saturation flag for the engine.
module shr_count_norm
  import shr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(2*DATA_W+1)+1,
  parameter int AMT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [2:0]       op_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             pass_o,
  output logic             left_o,
  output shr_kind_e        kind_o,
  output logic [AMT_W-1:0] amt_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] W_C = CNT_W'(DATA_W);

  logic                    neg;
  logic signed [CNT_W:0]   ext;
  logic [CNT_W-1:0]        mag;

  always_comb begin
    neg    = count_i[CNT_W-1];
    // one extra bit so that negating the most negative count cannot overflow
    ext    = signed'({count_i[CNT_W-1], count_i});
    mag    = neg ? CNT_W'(-ext) : count_i;
    pass_o = (op_i == OP_RS6) || (op_i == OP_RS7);
    left_o = ~op_i[0] ^ neg;
    kind_o = op_i[2] ? K_ROT : (op_i[1] ? K_ARI : K_LOG);
    if (kind_o == K_ROT) begin
      sat_o = 1'b0;
      amt_o = AMT_W'(mag % W_C);
    end else begin
      sat_o = (mag >= W_C);
      amt_o = sat_o ? '0 : AMT_W'(mag);
    end
  end

endmodule

// File: rtl/shr_engine.sv
// Left-only shift/rotate datapath; right-hand operations reuse it through
// bit reversal of input and output.
module shr_engine
  import shr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AMT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              pass_i,
  input  logic              left_i,
  input  shr_kind_e         kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] data_o
);

  function automatic logic [DATA_W-1:0] shl_fill(
    input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] a, input logic f);
    logic [DATA_W-1:0] keep;
    keep = {DATA_W{1'b1}} << a;
    return (v << a) | (f ? ~keep : '0);
  endfunction

  function automatic logic [DATA_W-1:0] rot_l(
    input logic [DATA_W-1:0] v, input logic [AMT_W-1:0] a);
    int unsigned back;
    if (a == '0) return v;
    back = DATA_W - int'(a);
    return (v << a) | (v >> back);
  endfunction

  logic [DATA_W-1:0] rev_in, rev_res, work, res;
  logic              fill;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign rev_in[g]  = data_i[DATA_W-1-g];
    assign rev_res[g] = res[DATA_W-1-g];
  end

  always_comb begin
    work = left_i ? data_i : rev_in;
    fill = (kind_i == K_ARI) ? work[0] : 1'b0;
    if (kind_i == K_ROT) res = rot_l(work, amt_i);
    else if (sat_i)      res = {DATA_W{fill}};
    else                 res = shl_fill(work, amt_i, fill);
    if (pass_i)          data_o = data_i;
    else                 data_o = left_i ? res : rev_res;
  end

endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(2*DATA_W+1)+1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        op_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int AMT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic             nrm_pass, nrm_left, nrm_sat;
  shr_kind_e        nrm_kind;
  logic [AMT_W-1:0] nrm_amt;

  shr_count_norm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AMT_W(AMT_W)) norm_i (
    .op_i    (op_i),
    .count_i (count_i),
    .pass_o  (nrm_pass),
    .left_o  (nrm_left),
    .kind_o  (nrm_kind),
    .amt_o   (nrm_amt),
    .sat_o   (nrm_sat)
  );

  shr_engine #(.DATA_W(DATA_W), .AMT_W(AMT_W)) eng_i (
    .data_i (data_i),
    .pass_i (nrm_pass),
    .left_i (nrm_left),
    .kind_i (nrm_kind),
    .amt_i  (nrm_amt),
    .sat_i  (nrm_sat),
    .data_o (data_o)
  );

  always_comb begin
    p_zero_pass_r2: assert (count_i != '0 || data_o == data_i)
      else $error("zero count altered data");
    p_reserved_pass_r9: assert (!(op_i == OP_RS6 || op_i == OP_RS7) || data_o == data_i)
      else $error("reserved code altered data");
    p_logic_sat_r3: assert (!(nrm_sat && nrm_kind == K_LOG && !nrm_pass) || data_o == '0)
      else $error("saturated logical shift not zero");
    p_arith_sat_r5: assert (!(nrm_sat && nrm_kind == K_ARI && !nrm_pass) ||
                            $countones(data_o) == 0 || $countones(data_o) == DATA_W)
      else $error("saturated arithmetic shift not uniform");
    p_rot_ones_r6: assert (!(nrm_kind == K_ROT && !nrm_pass) ||
                           $countones(data_o) == $countones(data_i))
      else $error("rotate changed population count");
  end

endmodule

// File: tb/shr_unit_tb_top.sv
module shr_unit_tb_top;

  localparam int CW8 = $clog2(17)+1;
  localparam int CW4 = $clog2(9)+1;
  localparam int CW1 = $clog2(3)+1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0]     d8, q8;
  logic [3:0]     d4, q4;
  logic [0:0]     d1, q1;
  logic [2:0]     op;
  logic [CW8-1:0] c8;
  logic [CW4-1:0] c4;
  logic [CW1-1:0] c1;

  shr_unit #(.DATA_W(8)) dut_i  (.data_i(d8), .op_i(op), .count_i(c8), .data_o(q8));
  shr_unit #(.DATA_W(4)) dut4_i (.data_i(d4), .op_i(op), .count_i(c4), .data_o(q4));
  shr_unit #(.DATA_W(1)) dut1_i (.data_i(d1), .op_i(op), .count_i(c1), .data_o(q1));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // one step of op on a w-bit value held in the low bits of v
  function automatic logic [7:0] step1(input logic [7:0] v, input int w, input int o);
    logic [7:0] m, r;
    m = 8'((9'd1 << w) - 9'd1);
    case (o)
      0: r = (v << 1);
      1: r = (v >> 1);
      2: r = (v << 1) | {7'd0, v[0]};
      3: r = (v >> 1) | (8'(v[w-1]) << (w-1));
      4: r = (v << 1) | {7'd0, v[w-1]};
      5: r = (v >> 1) | (8'(v[0]) << (w-1));
      default: r = v;
    endcase
    return r & m;
  endfunction

  function automatic logic [7:0] model(input logic [7:0] v, input int w, input int o, input int c);
    logic [7:0] r;
    int oo, n;
    r  = v;
    oo = o;
    n  = c;
    if (o > 5) return v;
    if (c < 0) begin oo = o ^ 1; n = -c; end
    for (int i = 0; i < n; i++) r = step1(r, w, oo);
    return r;
  endfunction

  task automatic check(input string req, input int w, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s w=%0d op=%0d actual=%b expected=%b", req, w, op, got, exp);
    end
  endtask

  task automatic apply(input int w, input logic [7:0] d, input int o, input int c);
    @(posedge clk); #1;
    op = 3'(o);
    d8 = d; d4 = d[3:0]; d1 = d[0:0];
    c8 = CW8'(c); c4 = CW4'(c); c1 = CW1'(c);
    @(negedge clk);
    if (w == 8) begin end
  endtask

  function automatic string tag(input int o, input int c);
    if (o > 5)  return "R9";
    if (c == 0) return "R2";
    if (c < 0)  return "R7";
    if (o < 2)  return "R3";
    if (o == 2) return "R4";
    if (o == 3) return "R5";
    return "R6";
  endfunction

  task automatic t_examples();
    apply(4, 8'b1011, 0, 3); check("R3", 4, {4'd0, q4}, 8'b1000);
    apply(4, 8'b1011, 1, 3); check("R3", 4, {4'd0, q4}, 8'b0001);
    apply(4, 8'b1011, 2, 1); check("R4", 4, {4'd0, q4}, 8'b0111);
    apply(4, 8'b1011, 2, 3); check("R4", 4, {4'd0, q4}, 8'b1111);
    apply(4, 8'b1011, 3, 1); check("R5", 4, {4'd0, q4}, 8'b1101);
    apply(4, 8'b1011, 3, 3); check("R5", 4, {4'd0, q4}, 8'b1111);
    apply(4, 8'b1011, 4, 3); check("R6", 4, {4'd0, q4}, 8'b1101);
    apply(4, 8'b1011, 5, 1); check("R6", 4, {4'd0, q4}, 8'b1101);
    apply(4, 8'b1011, 1, -3); check("R7", 4, {4'd0, q4}, 8'b1000);
    apply(8, 8'hA5, 0, 0);   check("R1", 8, q8, 8'hA5);
  endtask

  task automatic t_sweep();
    logic [7:0] pats [4] = '{8'hB3, 8'h01, 8'h80, 8'h5E};
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 8; o++)
        for (int c = -16; c <= 16; c++) begin
          apply(8, pats[p], o, c);
          check(tag(o, c), 8, q8, model(pats[p], 8, o, c));
          if (c >= -8 && c <= 8) check({tag(o, c), "/R10"}, 4, {4'd0, q4}, model(pats[p] & 8'h0F, 4, o, c));
          if (c >= -2 && c <= 2) check({tag(o, c), "/R10"}, 1, {7'd0, q1}, model(pats[p] & 8'h01, 1, o, c));
        end
  endtask

  task automatic t_min_count();
    for (int o = 0; o < 6; o++) begin
      apply(8, 8'hC9, o, -32);
      check("R8", 8, q8, model(8'hC9, 8, o, -32));
      apply(4, 8'h0D, o, -16);
      check("R8", 4, {4'd0, q4}, model(8'h0D, 4, o, -16));
      apply(1, 8'h01, o, -4);
      check("R8", 1, {7'd0, q1}, model(8'h01, 1, o, -4));
    end
  endtask

  initial begin
    op = '0; d8 = '0; d4 = '0; d1 = '0; c8 = '0; c4 = '0; c1 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(8, 8'h3C, 0, 0);
    check("R2", 8, q8, 8'h3C);
    t_examples();
    t_sweep();
    t_min_count();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule